// File: doc/BRIEF.md
# Keyed Flash Operation Controller

This block is the register front end for erase and program operations on a dual-partition flash. Software writes a destination address, then an unlock key pair, and then a control word that carries the start bit. The block checks the request and either rejects it with a sticky error flag or runs a timed behavioural operation. The start bit reads back as set for the whole operation. The flash array itself is outside the block. Only the control, the timing and the protection rules are modelled.

The address space is split at bit 22 of the 24-bit address. A target with that bit at 0 lies in the active (executing) partition, and a target with it at 1 lies in the inactive partition. An operation on the active partition holds the CPU stall output for its full length. An operation on the inactive partition runs in the background and ends with a one-cycle completion interrupt pulse. In protected dual mode, while physical partition 1 is mapped inactive (`p2_is_active` = 1), every operation on the inactive partition is refused.

Top module: `flash_op_ctrl`

## Requirements
- R1: After reset, ctl_start, ctl_wren, ctl_err, ctl_opcode, op_addr, cpu_stall and done_irq are all 0.
- R2: A start request counts only if the key register (reg_sel = 1, low 8 bits) received 55h and then AAh as its next key write, and the control write (reg_sel = 0, bit 15 = start) is captured in the clock cycle right after the AAh write. If any other value breaks the key pair, or if a cycle passes between AAh and the control write, the start bit is ignored.
- R3: A start request is ignored unless the write-enable bit (control bit 14) was already 1 before the write that carries it. That write still updates write-enable and the opcode.
- R4: An accepted operation holds ctl_start high for exactly PAGE_CYC, ROW_CYC or BULK_CYC cycles, and hardware then clears it. While ctl_start is high, writes to the control and address registers are ignored.
- R5: Opcode field bits 3:0 selects the operation: 0011 page erase, 0010 row program, 0100 erase of the whole inactive partition. Any other code with a valid start request sets ctl_err and leaves ctl_start at 0.
- R6: op_addr reports the target. A page erase clears address bits 9:0 (512 words). A row program clears bits 6:0 (64 words). A partition erase reports 400000h.
- R7: cpu_stall is high for every cycle of an operation whose target has address bit 22 = 0. It stays 0 for a target with bit 22 = 1 and for a partition erase.
- R8: done_irq pulses for one cycle, in the first cycle after ctl_start falls, and only for operations on the inactive partition.
- R9: With dual_protected = 1 and p2_is_active = 1, a request that targets the inactive partition (including partition erase) sets ctl_err and does not start. Targets in the active partition still run.
- R10: ctl_err stays set until a control write carries 0 in bit 13. Writing 1 in bit 13 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 key, 2 address, 3 unused |
| reg_wdata | input | 24 | Write data |
| dual_protected | input | 1 | Protected dual-partition mode |
| p2_is_active | input | 1 | Physical partition 2 is mapped active |
| ctl_start | output | 1 | Start/busy bit |
| ctl_wren | output | 1 | Write-enable bit |
| ctl_err | output | 1 | Sticky error flag |
| ctl_opcode | output | 4 | Stored opcode |
| op_addr | output | 24 | Aligned target of the last accepted operation |
| cpu_stall | output | 1 | CPU stall during an active-partition operation |
| done_irq | output | 1 | Completion pulse for an inactive-partition operation |

## Verification
The assertions take dual_protected and p2_is_active as static configuration that changes only while no operation runs. The protection and stall checks compare those inputs with the latched target one cycle after acceptance. They also rely on reg_sel value 3 being unused. The bench changes the mode inputs only between operations, while the block is idle. It never selects address 3, and it drives every register write for exactly one cycle between falling clock edges, so each key write and control write lands on a known edge.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_KEY  = 2'd1;
   localparam logic [1:0] SEL_ADDR = 2'd2;

   localparam int START_BIT = 15;
   localparam int WREN_BIT  = 14;
   localparam int ERR_BIT   = 13;

   localparam logic [3:0] OPC_ROW  = 4'b0010;
   localparam logic [3:0] OPC_PAGE = 4'b0011;
   localparam logic [3:0] OPC_BULK = 4'b0100;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_HALF = 2'd1,
      KS_OPEN = 2'd2
   } key_state_t;
endpackage

// File: rtl/flash_key_fsm.sv
module flash_key_fsm
   import flash_op_pkg::*;
#(
   parameter int KEY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_we,
   input  logic [KEY_W-1:0] key_data,
   output logic             window
);
   key_state_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KS_IDLE;
      end else if (key_we) begin
         if (key_data == KEY_W'(KEY_FIRST))
            state_q <= KS_HALF;
         else if (state_q == KS_HALF && key_data == KEY_W'(KEY_SECOND))
            state_q <= KS_OPEN;
         else
            state_q <= KS_IDLE;
      end else if (state_q == KS_OPEN) begin
         state_q <= KS_IDLE;
      end
   end

   assign window = (state_q == KS_OPEN);
endmodule

// File: rtl/flash_op_check.sv
module flash_op_check
   import flash_op_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int OP_W       = 4,
   parameter int PAGE_WORDS = 512,
   parameter int ROW_WORDS  = 64,
   parameter int CNT_W      = 16,
   parameter int PAGE_CYC   = 2000,
   parameter int ROW_CYC    = 400,
   parameter int BULK_CYC   = 20000,
   parameter bit PROTECT_EN = 1'b1
) (
   input  logic [OP_W-1:0]   opcode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              prot_mode,
   input  logic              p2_act,
   output logic              op_ok,
   output logic              tgt_inactive,
   output logic              prot_block,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [CNT_W-1:0]  op_cycles
);
   localparam int PAGE_LSB = $clog2(PAGE_WORDS) + 1;
   localparam int ROW_LSB  = $clog2(ROW_WORDS) + 1;
   localparam int PART_BIT = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'((64'd1 << PAGE_LSB) - 64'd1);
   localparam logic [ADDR_W-1:0] ROW_MASK  = ~ADDR_W'((64'd1 << ROW_LSB) - 64'd1);
   localparam logic [ADDR_W-1:0] PART_BASE = ADDR_W'(64'd1 << PART_BIT);

   always_comb begin
      op_ok        = 1'b1;
      tgt_inactive = addr[PART_BIT];
      tgt_addr     = addr;
      op_cycles    = CNT_W'(PAGE_CYC);
      case (opcode)
         OP_W'(OPC_PAGE): tgt_addr = addr & PAGE_MASK;
         OP_W'(OPC_ROW): begin
            tgt_addr  = addr & ROW_MASK;
            op_cycles = CNT_W'(ROW_CYC);
         end
         OP_W'(OPC_BULK): begin
            tgt_addr     = PART_BASE;
            tgt_inactive = 1'b1;
            op_cycles    = CNT_W'(BULK_CYC);
         end
         default: op_ok = 1'b0;
      endcase
   end

   generate
      if (PROTECT_EN) begin : g_protect
         assign prot_block = prot_mode & p2_act & tgt_inactive;
      end else begin : g_open
         assign prot_block = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            cnt_q <= load_val;
            busy  <= 1'b1;
         end else if (busy) begin
            if (cnt_q == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
   import flash_op_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 24,
   parameter int KEY_W      = 8,
   parameter int OP_W       = 4,
   parameter int PAGE_WORDS = 512,
   parameter int ROW_WORDS  = 64,
   parameter int PAGE_CYC   = 2000,
   parameter int ROW_CYC    = 400,
   parameter int BULK_CYC   = 20000,
   parameter bit PROTECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              dual_protected,
   input  logic              p2_is_active,
   output logic              ctl_start,
   output logic              ctl_wren,
   output logic              ctl_err,
   output logic [OP_W-1:0]   ctl_opcode,
   output logic [ADDR_W-1:0] op_addr,
   output logic              cpu_stall,
   output logic              done_irq
);
   localparam int MAX_CYC = (BULK_CYC > PAGE_CYC) ?
                            ((BULK_CYC > ROW_CYC) ? BULK_CYC : ROW_CYC) :
                            ((PAGE_CYC > ROW_CYC) ? PAGE_CYC : ROW_CYC);
   localparam int CNT_W = $clog2(MAX_CYC + 1);

   initial begin
      assert (DATA_W >= 16 && DATA_W >= ADDR_W && DATA_W >= KEY_W)
         else $error("flash_op_ctrl: DATA_W too narrow");
      assert (OP_W == 4 && KEY_W == 8) else $error("flash_op_ctrl: field widths");
      assert (PAGE_CYC >= 1 && ROW_CYC >= 1 && BULK_CYC >= 1)
         else $error("flash_op_ctrl: cycle counts must be positive");
      assert ($clog2(PAGE_WORDS) + 1 < ADDR_W - 2 && ROW_WORDS <= PAGE_WORDS)
         else $error("flash_op_ctrl: alignment sizes");
   end

   logic              busy, tmr_done, key_window;
   logic              wr_ctrl, wr_key, wr_addr;
   logic [ADDR_W-1:0] addr_q, tgt_addr;
   logic              op_ok, tgt_inactive, prot_block;
   logic [CNT_W-1:0]  op_cycles;
   logic              go_req, accept, reject;
   logic              stall_q, inact_q;

   assign wr_ctrl = reg_we && reg_sel == SEL_CTRL && !busy;
   assign wr_key  = reg_we && reg_sel == SEL_KEY;
   assign wr_addr = reg_we && reg_sel == SEL_ADDR && !busy;

   flash_key_fsm #(.KEY_W(KEY_W)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (wr_key),
      .key_data (reg_wdata[KEY_W-1:0]),
      .window   (key_window)
   );

   flash_op_check #(
      .ADDR_W(ADDR_W), .OP_W(OP_W), .PAGE_WORDS(PAGE_WORDS), .ROW_WORDS(ROW_WORDS),
      .CNT_W(CNT_W), .PAGE_CYC(PAGE_CYC), .ROW_CYC(ROW_CYC), .BULK_CYC(BULK_CYC),
      .PROTECT_EN(PROTECT_EN)
   ) u_chk_op (
      .opcode       (reg_wdata[OP_W-1:0]),
      .addr         (addr_q),
      .prot_mode    (dual_protected),
      .p2_act       (p2_is_active),
      .op_ok        (op_ok),
      .tgt_inactive (tgt_inactive),
      .prot_block   (prot_block),
      .tgt_addr     (tgt_addr),
      .op_cycles    (op_cycles)
   );

   assign go_req = wr_ctrl && key_window && reg_wdata[START_BIT] && ctl_wren;
   assign accept = go_req && op_ok && !prot_block;
   assign reject = go_req && !(op_ok && !prot_block);

   flash_op_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (op_cycles),
      .busy     (busy),
      .done     (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q     <= '0;
         ctl_wren   <= 1'b0;
         ctl_err    <= 1'b0;
         ctl_opcode <= '0;
         op_addr    <= '0;
         stall_q    <= 1'b0;
         inact_q    <= 1'b0;
      end else begin
         if (wr_addr)
            addr_q <= reg_wdata[ADDR_W-1:0];
         if (wr_ctrl) begin
            ctl_wren   <= reg_wdata[WREN_BIT];
            ctl_opcode <= reg_wdata[OP_W-1:0];
            if (reject)
               ctl_err <= 1'b1;
            else if (!reg_wdata[ERR_BIT])
               ctl_err <= 1'b0;
         end
         if (accept) begin
            op_addr <= tgt_addr;
            stall_q <= !tgt_inactive;
            inact_q <= tgt_inactive;
         end
      end
   end

   assign ctl_start = busy;
   assign cpu_stall = busy && stall_q;
   assign done_irq  = tmr_done && inact_q;
endmodule

// File: rtl/flash_op_ctrl_chk.sv
module flash_op_ctrl_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [1:0]        reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              dual_protected,
   input logic              p2_is_active,
   input logic              ctl_start,
   input logic              ctl_wren,
   input logic              ctl_err,
   input logic [ADDR_W-1:0] op_addr,
   input logic              cpu_stall,
   input logic              done_irq
);
   assert_start_by_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_start) |-> $past(reg_we && reg_sel == 2'd0 && reg_wdata[15]));

   assert_start_needs_wren_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_start) |-> $past(ctl_wren));

   assert_target_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_start && $past(ctl_start) |-> $stable(op_addr));

   assert_err_by_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_err) |-> $past(reg_we && reg_sel == 2'd0 && reg_wdata[15]));

   assert_stall_in_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |-> ctl_start && !op_addr[ADDR_W-2]);

   assert_stall_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_start && $past(ctl_start) |-> $stable(cpu_stall));

   assert_irq_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> !ctl_start && $past(ctl_start) && op_addr[ADDR_W-2]);

   assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_start) && $past(dual_protected && p2_is_active) |-> !op_addr[ADDR_W-2]);
endmodule

bind flash_op_ctrl flash_op_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_flash_op_ctrl.sv
module tb_flash_op_ctrl;
   localparam int PC = 8, RC = 4, BC = 12;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [23:0] reg_wdata = '0;
   logic        dual_protected = 1'b0, p2_is_active = 1'b0;
   logic        ctl_start, ctl_wren, ctl_err, cpu_stall, done_irq;
   logic [3:0]  ctl_opcode;
   logic [23:0] op_addr;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   flash_op_ctrl #(.PAGE_CYC(PC), .ROW_CYC(RC), .BULK_CYC(BC)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .dual_protected(dual_protected), .p2_is_active(p2_is_active),
      .ctl_start(ctl_start), .ctl_wren(ctl_wren), .ctl_err(ctl_err), .ctl_opcode(ctl_opcode),
      .op_addr(op_addr), .cpu_stall(cpu_stall), .done_irq(done_irq)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [23:0] addr;
      logic        prot;
      logic        p2;
      logic        e_err;
      logic [7:0]  e_len;
      logic        e_stall;
      logic        e_irq;
      logic        chk_addr;
      logic [23:0] e_addr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'h3, 24'h001234, 1'b0, 1'b0, 1'b0, 8'(PC), 1'b1, 1'b0, 1'b1, 24'h001000},
      '{4'h2, 24'h4000FF, 1'b0, 1'b0, 1'b0, 8'(RC), 1'b0, 1'b1, 1'b1, 24'h400080},
      '{4'h4, 24'h000500, 1'b0, 1'b0, 1'b0, 8'(BC), 1'b0, 1'b1, 1'b1, 24'h400000},
      '{4'h1, 24'h001000, 1'b0, 1'b0, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 24'h000000},
      '{4'hF, 24'h001000, 1'b0, 1'b0, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 24'h000000},
      '{4'h2, 24'h400200, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 24'h000000},
      '{4'h3, 24'h002400, 1'b1, 1'b1, 1'b0, 8'(PC), 1'b1, 1'b0, 1'b1, 24'h002400},
      '{4'h3, 24'h4007FF, 1'b1, 1'b0, 1'b0, 8'(PC), 1'b0, 1'b1, 1'b1, 24'h400400},
      '{4'h4, 24'h000000, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 24'h000000},
      '{4'h4, 24'h123456, 1'b0, 1'b1, 1'b0, 8'(BC), 1'b0, 1'b1, 1'b1, 24'h400000}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [23:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic unlock_start(input logic [3:0] op);
      wr(2'd1, 24'h000055);
      wr(2'd1, 24'h0000AA);
      wr(2'd0, 24'h00E000 | {20'd0, op});
   endtask

   task automatic measure(output int len, output bit stall_seen,
                          output bit irq1, output bit irq2);
      len = 0; stall_seen = 1'b0;
      while (ctl_start && len < 200) begin
         len++;
         stall_seen |= cpu_stall;
         @(negedge clk);
      end
      irq1 = done_irq;
      @(negedge clk);
      irq2 = done_irq;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int len;
      bit st, i1, i2;
      repeat (3) @(negedge clk);
      // R1: reset values
      check({ctl_start, ctl_wren, ctl_err, ctl_opcode, op_addr, cpu_stall, done_irq} == '0,
            "R1 reset state", {ctl_start, ctl_wren, ctl_err, cpu_stall, done_irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({ctl_start, ctl_wren, ctl_err, op_addr} == '0, "R1 after release",
            op_addr, 0);

      for (int i = 0; i < NV; i++) begin
         dual_protected = VECS[i].prot;
         p2_is_active   = VECS[i].p2;
         wr(2'd2, VECS[i].addr);
         wr(2'd0, 24'h004000 | {20'd0, VECS[i].op});
         unlock_start(VECS[i].op);
         measure(len, st, i1, i2);
         check(ctl_err == VECS[i].e_err, $sformatf("R5/R9 err vec%0d", i),
               ctl_err, VECS[i].e_err);
         check(len == int'(VECS[i].e_len), $sformatf("R4 length vec%0d", i),
               len, VECS[i].e_len);
         check(st == VECS[i].e_stall, $sformatf("R7 stall vec%0d", i), st, VECS[i].e_stall);
         check(i1 == VECS[i].e_irq && !i2, $sformatf("R8 irq vec%0d", i),
               {i1, i2}, {VECS[i].e_irq, 1'b0});
         if (VECS[i].chk_addr)
            check(op_addr == VECS[i].e_addr, $sformatf("R6 addr vec%0d", i),
                  op_addr, VECS[i].e_addr);
      end
      dual_protected = 1'b0; p2_is_active = 1'b0;

      // R10: error flag sticky, cleared only by writing 0
      wr(2'd0, 24'h004001);
      unlock_start(4'h1);
      check(ctl_err == 1'b1, "R10 err set", ctl_err, 1);
      wr(2'd0, 24'h006003);
      check(ctl_err == 1'b1, "R10 write 1 keeps err", ctl_err, 1);
      wr(2'd0, 24'h004003);
      check(ctl_err == 1'b0, "R10 write 0 clears err", ctl_err, 0);

      // R2: broken key sequence
      wr(2'd2, 24'h001000);
      wr(2'd1, 24'h000055);
      wr(2'd1, 24'h000033);
      wr(2'd1, 24'h0000AA);
      wr(2'd0, 24'h00C003);
      check(ctl_start == 1'b0 && ctl_err == 1'b0, "R2 wrong key ignored", ctl_start, 0);
      // R2: one idle cycle after AAh closes the window
      wr(2'd1, 24'h000055);
      wr(2'd1, 24'h0000AA);
      @(negedge clk);
      wr(2'd0, 24'h00C003);
      check(ctl_start == 1'b0, "R2 late start ignored", ctl_start, 0);

      // R3: write-enable must already be set
      wr(2'd0, 24'h000003);
      wr(2'd1, 24'h000055);
      wr(2'd1, 24'h0000AA);
      wr(2'd0, 24'h00C003);
      check(ctl_start == 1'b0 && ctl_wren == 1'b1, "R3 start without prior wren",
            {ctl_start, ctl_wren}, 2'b01);
      unlock_start(4'h3);
      check(ctl_start == 1'b1, "R3 start with wren", ctl_start, 1);

      // R4: register writes during an operation are ignored
      wr(2'd0, 24'h004002);
      wr(2'd2, 24'h4000FF);
      measure(len, st, i1, i2);
      check(len == PC - 2, "R4 remaining length", len, PC - 2);
      check(ctl_opcode == 4'h3 && ctl_wren == 1'b1, "R4 ctrl write ignored",
            ctl_opcode, 3);
      unlock_start(4'h3);
      measure(len, st, i1, i2);
      check(op_addr == 24'h001000 && st == 1'b1, "R4 addr write ignored",
            op_addr, 24'h001000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule